// File: doc/BRIEF.md
# Manchester Lighting-Bus Frame Receiver

This block recovers frames from a single-wire lighting control bus that carries Manchester-coded bits. Each bit lasts two half-bit times (TE), and every bit has a transition in its middle. The receiver samples the line with the system clock after a two-stage synchronizer. It derives TE in clock cycles from a clock-frequency parameter and a bit-period parameter when the design is elaborated. A polarity input selects whether the line is inverted before decoding. After that step, the bus rests low, and the rising edge in the middle of the start bit opens a frame.

Bits are rebuilt from pairs of half-bit phases. A phase ends at the next line transition. If no transition arrives, a phase ends 1.5 TE after the last edge, and the boundary is then placed 1.0 TE after that edge. The receiver does not use a fixed bit count. A pair of two high phases closes the frame. The frame is accepted when exactly 9 bits (a short, backward frame) or 17 bits (a long, forward frame) were collected, counting the start bit. Any other length, or an 18th bit, raises a one-cycle error pulse. The frame fields hold their values until the next accepted frame.

The controller has three states: `ST_IDLE`, `ST_PH0` and `ST_PH1`. Its transitions are:
- start: `ST_IDLE`→`ST_PH1`, on a rising edge.
- phase-0 taken: `ST_PH0`→`ST_PH1`.
- bit stored: `ST_PH1`→`ST_PH0`.
- stop accepted or stop rejected: `ST_PH1`→`ST_IDLE`.
- overflow: `ST_PH1`→`ST_IDLE`.

Top module: `lightbus_rx`

## Requirements
- R1: While reset is held and right after it is released, `frame_valid_o`, `frame_err_o`, `frame_fwd_o`, `level_o` and `payload_o` are all zero.
- R2: The decoded line is `line_i XOR active_high_i`. In idle, a rising edge of the decoded line starts a frame and is taken as the midpoint of the start bit, so the first phase of the start bit is 0. A frame started by a lone one-TE high pulse ends in an error and never in a valid pulse.
- R3: A phase ends at a decoded-line transition or 1.5 TE after the last edge, whichever comes first. Each bit equals the level of the second phase of its pair. Frames decode correctly when each run length deviates by up to TE/8.
- R4: When a pair of two high phases arrives with 9 bits collected, the receiver reports a backward frame. It gives one `frame_valid_o` pulse with `frame_fwd_o`=0. `level_o` holds the 8 bits after the start bit, the first received bit in bit 7. `payload_o` is 0.
- R5: When a pair of two high phases arrives with 17 bits collected, the receiver reports a forward frame. It gives one `frame_valid_o` pulse with `frame_fwd_o`=1. `payload_o` holds the 16 bits after the start bit, the first received bit in bit 15. `level_o` equals `payload_o[15:8]`.
- R6: A stop pair with any bit count other than 9 or 17 gives a `frame_err_o` pulse and no valid pulse, and the receiver returns to idle.
- R7: A non-stop pair that arrives when 17 bits are already held raises `frame_err_o` at once and returns to idle. No valid pulse follows for that frame.
- R8: With `active_high_i`=1, a line waveform that is the bitwise inverse of an active-low one decodes to the same frame.
- R9: `frame_valid_o` and `frame_err_o` are each high for one clock per event, and never in the same cycle.
- R10: `frame_fwd_o`, `level_o` and `payload_o` change only in a cycle where `frame_valid_o` is high. Error cases leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw bus line, asynchronous |
| active_high_i | input | 1 | 1: invert the line before decoding |
| frame_valid_o | output | 1 | One-cycle pulse when a frame is accepted |
| frame_fwd_o | output | 1 | 1: last frame was forward (17 bits), 0: backward (9 bits) |
| level_o | output | 8 | First data byte of the last accepted frame |
| payload_o | output | 16 | Forward frame data, zero after a backward frame |
| frame_err_o | output | 1 | One-cycle pulse on a bad length or an overflow |

## Verification
A phase pair that slips by one half-bit is the most likely internal fault. It shows at the ports as an error pulse within about four TE of the frame's last edge, or as a byte shifted by one bit. A bit count that is off by one turns a good frame into an error, or an overflow into a missing error. A timer that fires at the wrong count breaks decoding only for runs of two TE, which are the zero-to-one and one-to-zero bit sequences. Random data with per-run jitter reaches all of these faults. Hold-value checks after rejected frames catch fields that update when they should not.

// File: rtl/lightbus_pkg.sv
`timescale 1ns/1ps
package lightbus_pkg;
    localparam int DATA_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int LONG_BITS  = DATA_W + 1;
    localparam int SHORT_BITS = BYTE_W + 1;
    localparam int CNT_W      = $clog2(LONG_BITS + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH0  = 2'd1,
        ST_PH1  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/lightbus_sync.sv
`timescale 1ns/1ps
module lightbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic invert_i,
    output logic prev_o,
    output logic edge_o,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic [STAGES:0]   arm_q;
    logic              prev_q;
    logic              cur;
    logic              armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            arm_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_i ^ invert_i};
            arm_q  <= {arm_q[STAGES-1:0], 1'b1};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign cur    = sync_q[STAGES-1];
    assign armed  = arm_q[STAGES];
    assign prev_o = prev_q;
    assign edge_o = armed && (cur != prev_q);
    assign rise_o = edge_o && cur;

    assert_rise_from_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !prev_o == 1'b0);
endmodule

// File: rtl/lightbus_phase_timer.sv
`timescale 1ns/1ps
module lightbus_phase_timer #(
    parameter int TE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic edge_i,
    output logic evt_o
);
    localparam int T15 = TE_CYC + TE_CYC / 2;
    localparam int CW  = $clog2(T15 + 1);

    logic [CW-1:0] cnt_q;
    logic          expire;

    assign expire = (cnt_q == CW'(T15));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (edge_i) cnt_q <= '0;
        else if (expire) cnt_q <= CW'(T15 - TE_CYC);
        else             cnt_q <= cnt_q + CW'(1);
    end

    assign evt_o = run_i && (edge_i || expire);

    assert_timer_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(T15));
    assert_timer_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> cnt_q == '0);
endmodule

// File: rtl/lightbus_frame_fsm.sv
`timescale 1ns/1ps
module lightbus_frame_fsm
    import lightbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_i,
    input  logic                evt_i,
    input  logic                lvl_i,
    output logic                run_o,
    output logic                valid_o,
    output logic                err_o,
    output logic                fwd_o,
    output logic [BYTE_W-1:0]   level_o,
    output logic [DATA_W-1:0]   payload_o
);
    rx_state_e          st_q, st_d;
    logic               ph0_q, ph0_d;
    logic [CNT_W-1:0]   n_q, n_d;
    logic [DATA_W-1:0]  sh_q, sh_d;
    logic               accept, fail;
    logic               is_long;

    assign is_long = (n_q == CNT_W'(LONG_BITS));

    always_comb begin
        st_d   = st_q;
        ph0_d  = ph0_q;
        n_d    = n_q;
        sh_d   = sh_q;
        accept = 1'b0;
        fail   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (rise_i) begin
                    st_d  = ST_PH1;
                    ph0_d = 1'b0;
                    n_d   = '0;
                    sh_d  = '0;
                end
            end
            ST_PH0: begin
                if (evt_i) begin
                    ph0_d = lvl_i;
                    st_d  = ST_PH1;
                end
            end
            ST_PH1: begin
                if (evt_i) begin
                    if (lvl_i && ph0_q) begin
                        st_d = ST_IDLE;
                        if (is_long || n_q == CNT_W'(SHORT_BITS)) accept = 1'b1;
                        else                                       fail   = 1'b1;
                    end else if (is_long) begin
                        st_d = ST_IDLE;
                        fail = 1'b1;
                    end else begin
                        sh_d = {sh_q[DATA_W-2:0], lvl_i};
                        n_d  = n_q + CNT_W'(1);
                        st_d = ST_PH0;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ph0_q <= 1'b0;
            n_q   <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_d;
            ph0_q <= ph0_d;
            n_q   <= n_d;
            sh_q  <= sh_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            err_o     <= 1'b0;
            fwd_o     <= 1'b0;
            level_o   <= '0;
            payload_o <= '0;
        end else begin
            valid_o <= accept;
            err_o   <= fail;
            if (accept) begin
                fwd_o     <= is_long;
                level_o   <= is_long ? sh_q[DATA_W-1 -: BYTE_W] : sh_q[BYTE_W-1:0];
                payload_o <= is_long ? sh_q : '0;
            end
        end
    end

    assign run_o = (st_q != ST_IDLE);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        n_q <= CNT_W'(LONG_BITS));
    assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(level_o) && $stable(payload_o) && $stable(fwd_o)));
    assert_backward_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !fwd_o) |-> payload_o == '0);
endmodule

// File: rtl/lightbus_rx.sv
`timescale 1ns/1ps
module lightbus_rx #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BIT_NS      = 1_666_700,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_i,
    input  logic        active_high_i,
    output logic        frame_valid_o,
    output logic        frame_fwd_o,
    output logic [7:0]  level_o,
    output logic [15:0] payload_o,
    output logic        frame_err_o
);
    localparam longint TE_L   = (longint'(CLK_HZ) * longint'(BIT_NS)) / 64'd2_000_000_000;
    localparam int     TE_CYC = int'(TE_L);

    logic prev_lvl, line_edge, line_rise, run, evt;

    lightbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .invert_i (active_high_i),
        .prev_o   (prev_lvl),
        .edge_o   (line_edge),
        .rise_o   (line_rise)
    );

    lightbus_phase_timer #(.TE_CYC(TE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .edge_i (line_edge),
        .evt_o  (evt)
    );

    lightbus_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (line_rise),
        .evt_i     (evt),
        .lvl_i     (prev_lvl),
        .run_o     (run),
        .valid_o   (frame_valid_o),
        .err_o     (frame_err_o),
        .fwd_o     (frame_fwd_o),
        .level_o   (level_o),
        .payload_o (payload_o)
    );

    initial begin
        assert_te_sane_R3: assert (TE_CYC >= 4);
    end
endmodule

// File: tb/sim_lightbus_rx.sv
`timescale 1ns/1ps
module sim_lightbus_rx;
    localparam int TE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b0;
    logic        act_hi = 1'b0;
    logic        frame_valid, frame_fwd, frame_err;
    logic [7:0]  level;
    logic [15:0] payload;

    int checks = 0;
    int errors = 0;
    int n_val = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    lightbus_rx #(.CLK_HZ(50_000_000), .BIT_NS(640)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_i        (line),
        .active_high_i (act_hi),
        .frame_valid_o (frame_valid),
        .frame_fwd_o   (frame_fwd),
        .level_o       (level),
        .payload_o     (payload),
        .frame_err_o   (frame_err)
    );

    always @(negedge clk) begin
        if (frame_valid) n_val++;
        if (frame_err)   n_err++;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_level(input logic [31:0] d, input int nb);
        return (nb == 16) ? d[15:8] : d[7:0];
    endfunction

    function automatic logic [15:0] exp_payload(input logic [31:0] d, input int nb);
        return (nb == 16) ? d[15:0] : 16'h0;
    endfunction

    task automatic drive_run(input logic lvl, input int cycles);
        repeat (cycles) begin
            @(negedge clk);
            line = lvl ^ act_hi;
        end
    endtask

    task automatic send_frame(input logic [31:0] data, input int nb, input bit jit);
        logic [127:0] ph;
        int np;
        int i;
        ph = '0;
        ph[0] = 1'b0;
        ph[1] = 1'b1;
        np = 2;
        for (int k = nb - 1; k >= 0; k--) begin
            ph[np]     = ~data[k];
            ph[np + 1] = data[k];
            np += 2;
        end
        for (int k = 0; k < 4; k++) begin ph[np] = 1'b1; np++; end
        for (int k = 0; k < 4; k++) begin ph[np] = 1'b0; np++; end
        i = 0;
        while (i < np) begin
            int j;
            int len;
            j = i;
            while (j < np && ph[j] == ph[i]) j++;
            len = (j - i) * TE;
            if (jit && i != 0 && j != np) len += int'($urandom_range(4, 0)) - 2;
            drive_run(ph[i], len);
            i = j;
        end
    endtask

    task automatic set_pol(input bit pol);
        @(negedge clk);
        act_hi = pol;
        line   = pol;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame_case(input string tag, input logic [31:0] data, input int nb,
                              input bit pol, input bit jit);
        logic [7:0]  old_lvl;
        logic [15:0] old_pl;
        logic        old_fwd;
        set_pol(pol);
        old_lvl = level;
        old_pl  = payload;
        old_fwd = frame_fwd;
        n_val = 0;
        n_err = 0;
        send_frame(data, nb, jit);
        repeat (2 * TE) @(negedge clk);
        if (nb == 8 || nb == 16) begin
            chk(tag, "valid pulses (R9)", n_val, 1);
            chk(tag, "error pulses", n_err, 0);
            chk(tag, "forward flag", frame_fwd, (nb == 16));
            chk(tag, "level byte", level, exp_level(data, nb));
            chk(tag, "payload", payload, exp_payload(data, nb));
        end else begin
            chk(tag, "valid pulses on reject", n_val, 0);
            chk(tag, "error seen", (n_err != 0), 1);
            chk({tag, " R10"}, "level held", level, old_lvl);
            chk({tag, " R10"}, "payload held", payload, old_pl);
            chk({tag, " R10"}, "fwd held", frame_fwd, old_fwd);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", frame_valid, 0);
        chk("R1", "err in reset", frame_err, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "valid after reset", frame_valid, 0);
        chk("R1", "fwd after reset", frame_fwd, 0);
        chk("R1", "level after reset", level, 0);
        chk("R1", "payload after reset", payload, 0);

        frame_case("R4 backward", 32'hA5, 8, 1'b0, 1'b0);
        frame_case("R5 forward", 32'h1234, 16, 1'b0, 1'b0);
        frame_case("R4 R8 backward zeros inverted", 32'h00, 8, 1'b1, 1'b0);
        frame_case("R5 R8 forward ones inverted", 32'hFFFF, 16, 1'b1, 1'b0);
        frame_case("R3 alternating", 32'h5A5A, 16, 1'b0, 1'b1);
        frame_case("R6 four bits", 32'h9, 4, 1'b0, 1'b0);
        frame_case("R6 twelve bits", 32'hABC, 12, 1'b1, 1'b0);
        frame_case("R7 overflow", 32'h5_5555, 19, 1'b0, 1'b0);

        set_pol(1'b0);
        n_val = 0;
        n_err = 0;
        drive_run(1'b1, TE);
        drive_run(1'b0, 50 * TE);
        chk("R2 lone pulse", "valid pulses", n_val, 0);
        chk("R2 lone pulse", "error seen", (n_err != 0), 1);

        for (int it = 0; it < 16; it++) begin
            int nb;
            logic [31:0] d;
            bit pol;
            nb  = ($urandom % 2 == 0) ? 8 : 16;
            d   = $urandom & ((nb == 16) ? 32'hFFFF : 32'hFF);
            pol = $urandom % 2;
            frame_case((nb == 16) ? "R5 R3 random" : "R4 R3 random", d, nb, pol, 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule